// File: doc/BRIEF.md
# Flip-Flop Word Store with Byte-Lane Writes

This block is a single-port memory of 256 words by 32 bits in which every stored bit is a D flip-flop on one shared clock. A write happens at a rising edge when the chip enable is high. Each of the four byte lanes has its own write enable. The word is picked by an address decode built in stages: address bit pairs go to four-line groups, and neighbouring groups are then merged until one line per word is left. Each bit either takes its lane's write data or feeds back its own value through a 2:1 choice. No write strobe, no change.

The read side turns the address into a one-hot word select and registers it on every clock edge. The selected word then passes through a reduction tree. Its first layer gates each word with its select bit through NAND2 gates. Each later layer halves the count, and the layers alternate NAND2 and NOR2. The last stage merges the tree root with the synchronous reset, so a high reset forces the read data to zero in the same cycle. The array contents are never cleared by reset.

The data pins are plain level-sampled signals with no valid/ready handshake. A memory built from flip-flops accepts an access on every clock and cannot stall, so back-pressure never applies.

Top module: `ffram_bytewise`

## Requirements
- R1: While `rst_i` is high, `rdata_o` is all zeros in that same cycle, whatever word is selected.
- R2: At a rising edge with `ce_i` high, every lane b with `we_i[b]` high loads `wdata_i[8b+7:8b]` into bits 8b+7..8b of word `addr_i`. Lanes of that word whose enable is low keep their value.
- R3: At a rising edge with `ce_i` low, no stored bit changes, whatever the value of `we_i`.
- R4: A write changes only the addressed word. Every other word keeps its contents.
- R5: At each rising edge with `rst_i` low, the read select captures `addr_i`. Until the next edge, `rdata_o` shows the current contents of the captured word.
- R6: When an edge both writes word A and captures A as the read select, `rdata_o` after that edge shows the newly written bytes in the written lanes and the previous bytes elsewhere.
- R7: A rising edge with `rst_i` high clears the read select. After `rst_i` falls, `rdata_o` stays zero until the next edge captures an address.
- R8: Each of the 256 addresses, 0 and 255 included, reaches its own distinct word.
- R9: Writes are still carried out while `rst_i` is high. Reset does not alter the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all storage and select flip-flops |
| rst_i | input | 1 | Synchronous reset; forces read data to zero and clears the select |
| ce_i | input | 1 | Chip enable; when low, no write takes place |
| we_i | input | 4 | Per-lane write enables; bit b covers data bits 8b+7..8b |
| addr_i | input | 8 | Word address for both writing and read select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the word selected at the last edge |

## Verification
Writes and the read select both take effect at the rising edge where they are presented. The matching `rdata_o` value is therefore due one edge after the stimulus, and the bench samples it at the following falling edge, once the edge has settled. Reset gating is combinational, so the bench also samples 1 ns after raising `rst_i`, before any edge, to check the same-cycle zero. The behavioural model updates its select and array at the same edge as the design, and it applies the write before the read so that a same-address read sees the new bytes.

// File: rtl/ffram_pkg.sv
package ffram_pkg;
  localparam int LANE_W = 8;

  // Level of heap node 'node' in a complete binary tree of 'depth' levels,
  // counting leaves' parents as level 1 and the root as level 'depth'.
  function automatic int heap_level(input int node, input int depth);
    return depth - ($clog2(node + 1) - 1);
  endfunction

  // Number of leaves below heap node 'node' when the tree has 'nleaf' leaves.
  function automatic int heap_span(input int node, input int nleaf);
    return nleaf >> ($clog2(node + 1) - 1);
  endfunction
endpackage

// File: rtl/ffram_addr_decode.sv
// Staged address decode: bit pairs -> 4-line groups, then neighbouring
// groups merged pairwise up a heap until one line per word remains.
// ADDR_W must be 2 times a power of two (2, 4, 8).
module ffram_addr_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]      addr,
  output logic [(1<<ADDR_W)-1:0] lines
);
  import ffram_pkg::*;

  localparam int WORDS  = 1 << ADDR_W;
  localparam int GROUPS = ADDR_W / 2;

  logic [WORDS-1:0] gn [1:2*GROUPS-1];

  // Leaf groups: one-hot of four per address bit pair.
  for (genvar j = 0; j < GROUPS; j++) begin : g_leaf
    logic [WORDS-1:0] v;
    always_comb begin
      v = '0;
      v[addr[2*j +: 2]] = 1'b1;
    end
    assign gn[GROUPS + j] = v;
  end

  // Merge nodes: high child supplies the upper address bits.
  for (genvar i = 1; i < GROUPS; i++) begin : g_merge
    localparam int SPAN = heap_span(i, GROUPS);
    localparam int CW   = 1 << SPAN;
    logic [WORDS-1:0] v;
    always_comb begin
      v = '0;
      for (int h = 0; h < CW; h++) begin
        for (int l = 0; l < CW; l++) begin
          v[h*CW + l] = gn[2*i+1][h] & gn[2*i][l];
        end
      end
    end
    assign gn[i] = v;
  end

  assign lines = gn[1];

  // R8: every address reaches exactly one word line
  always_comb begin
    a_r8_lines_onehot: assert ($onehot(lines) || $isunknown(addr));
  end
endmodule

// File: rtl/ffram_store.sv
// Flip-flop array: each lane of each word recirculates unless strobed.
module ffram_store #(
  parameter int WORDS  = 256,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ce,
  input  logic [DATA_W/ffram_pkg::LANE_W-1:0] we,
  input  logic [WORDS-1:0]              lines,
  input  logic [DATA_W-1:0]             wdata,
  output logic [WORDS-1:0][DATA_W-1:0]  mem
);
  import ffram_pkg::*;

  localparam int LANES = DATA_W / LANE_W;

  logic [WORDS-1:0][LANES-1:0] strobe;
  logic [WORDS-1:0]            word_hit;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign strobe[w][b] = lines[w] & ce & we[b];
      always_ff @(posedge clk) begin
        mem[w][b*LANE_W +: LANE_W] <= strobe[w][b] ? wdata[b*LANE_W +: LANE_W]
                                                   : mem[w][b*LANE_W +: LANE_W];
      end
    end
    assign word_hit[w] = |strobe[w];
  end

  // R3: a disabled chip leaves the whole array untouched
  a_r3_ce_low_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(mem));

  // R4: at most one word is strobed in any cycle
  a_r4_single_word: assert property (@(posedge clk) disable iff (rst)
    $onehot0(word_hit));
endmodule

// File: rtl/ffram_read_tree.sv
// Select-and-reduce tree held as a heap: leaves gate each word with its
// select through NAND2, parents alternate NAND2 (odd level) / NOR2 (even).
module ffram_read_tree #(
  parameter int WORDS  = 256,
  parameter int DATA_W = 32
) (
  input  logic [WORDS-1:0]             sel,
  input  logic [WORDS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]            root
);
  import ffram_pkg::*;

  localparam int DEPTH = $clog2(WORDS);

  logic [DATA_W-1:0] nd [1:2*WORDS-1];

  for (genvar w = 0; w < WORDS; w++) begin : g_gate
    assign nd[WORDS + w] = ~(words[w] & {DATA_W{sel[w]}});
  end

  for (genvar i = 1; i < WORDS; i++) begin : g_node
    localparam int LV = heap_level(i, DEPTH);
    if (LV % 2 == 1) begin : g_nand
      assign nd[i] = ~(nd[2*i] & nd[2*i+1]);
    end else begin : g_nor
      assign nd[i] = ~(nd[2*i] | nd[2*i+1]);
    end
  end

  assign root = nd[1];
endmodule

// File: rtl/ffram_bytewise.sv
module ffram_bytewise #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               ce_i,
  input  logic [DATA_W/ffram_pkg::LANE_W-1:0] we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [DATA_W-1:0]                  rdata_o
);
  import ffram_pkg::*;

  localparam int WORDS = 1 << ADDR_W;
  localparam int DEPTH = ADDR_W;

  logic [WORDS-1:0]             lines;
  logic [WORDS-1:0]             sel_q;
  logic [WORDS-1:0][DATA_W-1:0] mem;
  logic [DATA_W-1:0]            root;

  ffram_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr  (addr_i),
    .lines (lines)
  );

  ffram_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk   (clk_i),
    .rst   (rst_i),
    .ce    (ce_i),
    .we    (we_i),
    .lines (lines),
    .wdata (wdata_i),
    .mem   (mem)
  );

  // Registered one-hot read select.
  always_ff @(posedge clk_i) begin
    if (rst_i) sel_q <= '0;
    else       sel_q <= lines;
  end

  ffram_read_tree #(.WORDS(WORDS), .DATA_W(DATA_W)) u_tree (
    .sel   (sel_q),
    .words (mem),
    .root  (root)
  );

  // Final stage merges reset; root polarity depends on tree depth parity.
  if (DEPTH % 2 == 0) begin : g_out_inv
    assign rdata_o = ~(root | {DATA_W{rst_i}});
  end else begin : g_out_true
    assign rdata_o = root & ~{DATA_W{rst_i}};
  end

  // R1: reset zeroes the read data in the same cycle
  always_comb begin
    if (rst_i) a_r1_reset_zero: assert (rdata_o == '0);
  end

  // R5: the select register follows the address of the previous edge
  a_r5_sel_tracks_addr: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (sel_q == (WORDS'(1) << $past(addr_i))));

  // R7: leaving reset, nothing is selected yet
  a_r7_reset_clears_sel: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (sel_q == '0));
endmodule

// File: tb/ffram_bytewise_tb_top.sv
module ffram_bytewise_tb_top;
  localparam int NW = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic [3:0]  we = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [31:0] ref_mem [NW];
  int          ref_sel = -1;

  always #2 clk = ~clk;

  ffram_bytewise dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .ce_i    (ce),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_out();
    if (rst || ref_sel < 0) return 32'h0;
    return ref_mem[ref_sel];
  endfunction

  // Called at a falling edge: drive, step one clock, compare at next falling edge.
  task automatic step(input string req, input bit r, input bit c,
                      input logic [3:0] w, input logic [7:0] a, input logic [31:0] d);
    rst = r; ce = c; we = w; addr = a; wdata = d;
    #1;
    if (r) check("R1", rdata, 32'h0);
    @(posedge clk);
    if (c) begin
      for (int b = 0; b < 4; b++)
        if (w[b]) ref_mem[a][8*b +: 8] = d[8*b +: 8];
    end
    ref_sel = r ? -1 : int'(a);
    @(negedge clk);
    check(req, rdata, model_out());
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run not finished, expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    // R9 and R1: fill all words while reset is held, output must stay zero.
    for (int w = 0; w < NW; w++) begin
      step("R9", 1'b1, 1'b1, 4'hF, 8'(w),
           {8'(w), ~8'(w), 8'(w) ^ 8'h5A, 8'(w + 1)});
    end
    // R7: reset released, no edge yet, nothing selected.
    rst = 1'b0; ce = 1'b0; we = '0;
    #1;
    check("R7", rdata, 32'h0);
    @(negedge clk);
    // R8: every address reads its own pattern (reads back R9 fill too).
    for (int w = NW - 1; w >= 0; w--) begin
      step("R8", 1'b0, 1'b0, 4'h0, 8'(w), 32'h0);
    end
    // R6: write lanes 0 and 2 of word 10 while selecting it.
    step("R6", 1'b0, 1'b1, 4'b0101, 8'd10, 32'hA1B2C3D4);
    // R2: read back word 10, lanes 1 and 3 unchanged.
    step("R2", 1'b0, 1'b0, 4'h0, 8'd10, 32'h0);
    step("R2", 1'b0, 1'b1, 4'b1000, 8'd10, 32'h77000000);
    step("R2", 1'b0, 1'b0, 4'h0, 8'd10, 32'h0);
    // R3: chip disabled, all lanes enabled, no change.
    step("R3", 1'b0, 1'b0, 4'hF, 8'd10, 32'hDEADBEEF);
    step("R3", 1'b0, 1'b0, 4'h0, 8'd10, 32'h0);
    // R4: neighbours untouched.
    step("R4", 1'b0, 1'b0, 4'h0, 8'd9, 32'h0);
    step("R4", 1'b0, 1'b0, 4'h0, 8'd11, 32'h0);
    // R8 boundary words.
    step("R8", 1'b0, 1'b1, 4'hF, 8'd0, 32'h01234567);
    step("R8", 1'b0, 1'b1, 4'hF, 8'd255, 32'h89ABCDEF);
    step("R8", 1'b0, 1'b0, 4'h0, 8'd0, 32'h0);
    step("R8", 1'b0, 1'b0, 4'h0, 8'd255, 32'h0);
    // R1 during a read, then R7 on release.
    step("R1", 1'b1, 1'b0, 4'h0, 8'd255, 32'h0);
    rst = 1'b0; ce = 1'b0; #1;
    check("R7", rdata, 32'h0);
    @(negedge clk);
    // R5: random mix of byte writes, reads and occasional resets.
    for (int n = 0; n < 4000; n++) begin
      bit          r = ($urandom % 32) == 0;
      bit          c = ($urandom % 4) != 0;
      logic [3:0]  w = 4'($urandom);
      logic [7:0]  a = (n % 2 == 0) ? 8'($urandom % 16) : 8'($urandom);
      step("R5", r, c, w, a, $urandom);
    end
    done = 1'b1;
    finish_run();
  end
endmodule